// File: doc/BRIEF.md
# Selectable Four-Bit Arithmetic Circuit

This block is a purely combinational arithmetic stage for a small register-transfer datapath. One ripple binary adder forms the sum of operand A, a derived second operand and a single carry-in bit. The derived operand comes from a four-way selector. It can be operand B as given, B with every bit inverted, a word of zeros, or a word of ones.

Pairing each selector setting with the carry-in gives eight operations from the one adder:
- add, and add with carry;
- subtract, and subtract with borrow;
- two forms of transfer;
- increment and decrement.

The carry out of the top bit is brought out unchanged for every operation. The surrounding datapath can use it as a carry for addition or as a no-borrow flag for subtraction. The operand width is a parameter with a default of 4 bits.

Top module: `sel_arith_unit`

## Requirements
- R1: With sel = 2'b00 the outputs satisfy {carry_out, d_out} = a_in + b_in + carry_in. This covers plain add (carry_in = 0) and add with carry (carry_in = 1).
- R2: With sel = 2'b01 and carry_in = 1, d_out = (a_in - b_in) mod 16. carry_out is 1 exactly when a_in >= b_in, meaning no borrow.
- R3: With sel = 2'b01 and carry_in = 0, d_out = (a_in - b_in - 1) mod 16. carry_out is 1 exactly when a_in > b_in.
- R4: With sel = 2'b10 and carry_in = 0, d_out = a_in and carry_out = 0.
- R5: With sel = 2'b10 and carry_in = 1, d_out = (a_in + 1) mod 16. carry_out is 1 only when a_in = 4'hF.
- R6: With sel = 2'b11 and carry_in = 0, d_out = (a_in - 1) mod 16. carry_out is 1 for every a_in except 0.
- R7: With sel = 2'b11 and carry_in = 1, d_out = a_in and carry_out = 1.
- R8: When sel[1] = 1, b_in has no effect on d_out or carry_out.
- R9: For every sel and carry_in, carry_out is the unmasked carry out of the most significant bit of a_in + Y + carry_in. Y is b_in, ~b_in, all zeros or all ones for sel = 00, 01, 10, 11 respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First adder operand |
| b_in | input | WIDTH | Source for the second adder operand |
| sel | input | 2 | Second-operand select: 00 = B, 01 = ~B, 10 = zeros, 11 = ones |
| carry_in | input | 1 | Carry into bit 0 |
| d_out | output | WIDTH | Sum word |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
All four select codes are combined with both carry-in values and every pair of 4-bit operands. Each result is compared against a sum of integers formed in the bench.

The patterns are chosen to separate specific faults:
- The two subtract settings with a_in equal to b_in, and with a_in one above or below b_in, expose a wrong carry-in or a missing inversion through the no-borrow carry.
- The wrap points a_in = 0 and a_in = 15 under increment and decrement separate a broken top-bit carry from a broken low-order sum.
- A dedicated pass holds a_in fixed and steps b_in under the zero and ones selects. It shows whether b_in leaks into the result.

// File: rtl/sel_arith_unit.sv
module sel_arith_unit #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [1:0]       sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] d_out,
  output logic             carry_out
);

  logic [WIDTH-1:0] y_op;
  logic [WIDTH:0]   carry;

  always_comb begin
    unique case (sel)
      2'b00:   y_op = b_in;
      2'b01:   y_op = ~b_in;
      2'b10:   y_op = '0;
      default: y_op = '1;
    endcase
  end

  assign carry[0] = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign d_out[i]   = a_in[i] ^ y_op[i] ^ carry[i];
    assign carry[i+1] = (a_in[i] & y_op[i]) | (carry[i] & (a_in[i] ^ y_op[i]));
  end

  assign carry_out = carry[WIDTH];

endmodule

// File: rtl/sel_arith_unit_chk.sv
module sel_arith_unit_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [1:0]       sel,
  input logic             carry_in,
  input logic [WIDTH-1:0] d_out,
  input logic             carry_out
);

  localparam int W1 = WIDTH + 1;

  logic [W1-1:0] full;
  logic [W1-1:0] a_x, b_x, ci_x;

  assign full = {carry_out, d_out};
  assign a_x  = W1'(a_in);
  assign b_x  = W1'(b_in);
  assign ci_x = W1'(carry_in);

  always_comb begin
    if (sel == 2'b00)
      a_r1_add: assert (full == a_x + b_x + ci_x);
    if (sel == 2'b01 && carry_in)
      a_r2_sub: assert (d_out == a_in - b_in && carry_out == (a_in >= b_in));
    if (sel == 2'b01 && !carry_in)
      a_r3_sub_borrow: assert (d_out == a_in - b_in - WIDTH'(1) && carry_out == (a_in > b_in));
    if (sel == 2'b10 && !carry_in)
      a_r4_transfer: assert (d_out == a_in && !carry_out);
    if (sel == 2'b10 && carry_in)
      a_r5_increment: assert (full == a_x + W1'(1));
    if (sel == 2'b11 && !carry_in)
      a_r6_decrement: assert (d_out == a_in - WIDTH'(1) && carry_out == (a_in != '0));
    if (sel == 2'b11 && carry_in)
      a_r7_transfer_ones: assert (d_out == a_in && carry_out);
  end

endmodule

bind sel_arith_unit sel_arith_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in(a_in), .b_in(b_in), .sel(sel), .carry_in(carry_in),
  .d_out(d_out), .carry_out(carry_out)
);

// File: tb/sel_arith_unit_tb.sv
module sel_arith_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 4;
  localparam int SPAN = 1 << WIDTH;

  logic             clk = 1'b0;
  logic [WIDTH-1:0] a_in = '0;
  logic [WIDTH-1:0] b_in = '0;
  logic [1:0]       sel = 2'b00;
  logic             carry_in = 1'b0;
  logic [WIDTH-1:0] d_out;
  logic             carry_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sel_arith_unit #(.WIDTH(WIDTH)) u_dut (
    .a_in(a_in), .b_in(b_in), .sel(sel), .carry_in(carry_in),
    .d_out(d_out), .carry_out(carry_out)
  );

  function automatic string req_tag(input logic [1:0] s, input logic c);
    case (s)
      2'b00:   return "R1/R9";
      2'b01:   return c ? "R2/R9" : "R3/R9";
      2'b10:   return c ? "R5/R9" : "R4/R9";
      default: return c ? "R7/R9" : "R6/R9";
    endcase
  endfunction

  task automatic apply(input int s, input int c, input int a, input int b);
    @(posedge clk);
    #1;
    sel = 2'(s);
    carry_in = 1'(c);
    a_in = WIDTH'(a);
    b_in = WIDTH'(b);
    @(negedge clk);
  endtask

  task automatic check_vec(input int s, input int c, input int a, input int b, input string tag);
    int y, total, exp_d, exp_c;
    case (s)
      0:       y = b;
      1:       y = (SPAN - 1) - b;
      2:       y = 0;
      default: y = SPAN - 1;
    endcase
    total = a + y + c;
    exp_d = total % SPAN;
    exp_c = (total / SPAN) % 2;
    apply(s, c, a, b);
    checks++;
    if (int'(d_out) != exp_d || int'(carry_out) != exp_c) begin
      fails++;
      $display("FAIL %s sel=%0d cin=%0d a=%0d b=%0d: got d=%0d c=%0d, expected d=%0d c=%0d",
               tag, s, c, a, b, d_out, carry_out, exp_d, exp_c);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R9: got hung run, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    check_vec(0, 0, 0, 0, "R1 idle zero");
    check_vec(0, 1, 15, 15, "R1 max add with carry");
    check_vec(1, 1, 7, 7, "R2 equal operands");
    check_vec(1, 1, 6, 7, "R2 borrow");
    check_vec(1, 0, 7, 7, "R3 equal operands");
    check_vec(1, 0, 8, 7, "R3 one above");
    check_vec(2, 0, 9, 3, "R4 transfer");
    check_vec(2, 1, 15, 0, "R5 increment wrap");
    check_vec(3, 0, 0, 0, "R6 decrement wrap");
    check_vec(3, 1, 5, 12, "R7 transfer ones");

    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < SPAN; a++)
          for (int b = 0; b < SPAN; b++)
            check_vec(s, c, a, b, req_tag(2'(s), 1'(c)));

    for (int s = 2; s < 4; s++)
      for (int c = 0; c < 2; c++) begin
        logic [WIDTH-1:0] ref_d;
        logic             ref_c;
        apply(s, c, 10, 0);
        ref_d = d_out;
        ref_c = carry_out;
        for (int b = 1; b < SPAN; b++) begin
          apply(s, c, 10, b);
          checks++;
          if (d_out != ref_d || carry_out != ref_c) begin
            fails++;
            $display("FAIL R8 sel=%0d cin=%0d b=%0d: got d=%0d c=%0d, expected d=%0d c=%0d",
                     s, c, b, d_out, carry_out, ref_d, ref_c);
          end
        end
      end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule